// File: doc/BRIEF.md
# Floppy Drive Phase Select and Strobe Sequencer

This block drives the phase-line interface of a floppy drive. The drive is told what to do, and asked about its state, through a 4-bit code. The low three code bits go out on three phase lines and the top bit goes out on a separate drive-select line. Once the code has settled, the block either pulses a strobe, which makes the drive perform the coded action, or samples the drive's single sense line. The sense line is active low, so the block returns a 1 when it reads 0.

A host hands over one command at a time: a code, plus a flag that says whether the command is an action or a sense. Every command first puts the relax code (3) on the phase lines for one cycle and only then applies the new code. All delays come from a cycles-per-microsecond parameter. An action holds the code for 1 us of setup, raises the strobe for 2 us, then waits another 1 us before the block goes idle. A sense holds the code for 1 us, captures the inverted sense line, and puts the phase lines back to relax in the same cycle. A busy output covers each command from acceptance to its last cycle, and any request made while busy is dropped.

The drive's own behaviour is outside this block. Typical action codes are: step direction positive (0), step direction negative (4), step (1), motor on (2), motor off (6), eject (7), MFM mode (9) and GCR mode (13). Sense codes select drive conditions such as disk in (8), write protect (9), track zero (10) and seek complete (14).

Top module: `drive_phase_sequencer`

## Requirements
- R1: After reset, phaseLines is 3, driveSel is 0, strobe is 0, busy is 0 and senseValid is 0.
- R2: A request (reqValid high while busy is low) is accepted at a clock edge. In the cycle after that edge, busy is 1 and phaseLines is the relax code 3, whatever code was requested.
- R3: One cycle after acceptance, phaseLines equals reqCode[2:0] and driveSel equals reqCode[3]. Both keep these values for as long as the command is running.
- R4: For an action (reqSense = 0), strobe goes high SETUP_US*CYC_PER_US cycles after the code is applied. It stays high for exactly STROBE_US*CYC_PER_US cycles, and the phase lines do not change while it is high.
- R5: An action ends HOLD_US*CYC_PER_US cycles after strobe falls. At that point busy goes low, and phaseLines and driveSel keep the action's code until the next command.
- R6: For a sense (reqSense = 1), senseValid pulses for one cycle SETUP_US*CYC_PER_US cycles after the code is applied. In that cycle senseBit is the inverse of senseIn, busy is low and phaseLines is back to 3. driveSel keeps reqCode[3]. strobe never rises during a sense.
- R7: A request made while busy is 1 is ignored. It changes neither the lines nor the timing of the running command, and it does not start a new command once busy drops.
- R8: senseBit keeps its value between sense commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command request, taken when busy is low |
| reqCode | input | 4 | Command code: bits 2:0 go to the phase lines, bit 3 to the drive-select line |
| reqSense | input | 1 | 1 = sense command, 0 = action command |
| busy | output | 1 | High while a command is running |
| phaseLines | output | 3 | Phase lines to the drive |
| driveSel | output | 1 | Drive-select line |
| strobe | output | 1 | Action strobe to the drive |
| senseIn | input | 1 | Sense line from the drive, active low |
| senseValid | output | 1 | One-cycle pulse when a sensed bit is captured |
| senseBit | output | 1 | Last sensed bit, 1 when the line read 0 |

## Verification
Let U = CYC_PER_US and count edge 0 as the acceptance edge. The relax code is visible after edge 0 and the new code after edge 1. For an action, strobe rises after edge 1+U and falls after edge 1+3U, and busy drops after edge 1+4U. For a sense, senseValid, the return to relax and the fall of busy all appear after edge 1+U. The bench drives and samples on the falling clock edge. After each rising edge it compares every output against a per-cycle expectation built from these offsets, for random and directed codes. It also issues stray requests while busy, including one in the last busy cycle, and checks that none of them starts a command.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RELAX = 3'd1,
    ST_SETUP = 3'd2,
    ST_PULSE = 3'd3,
    ST_HOLD  = 3'd4
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldRelax;   // latch request code, drive relax code
    logic ldCode;    // drive latched code onto the lines
    logic strobeOn;  // raise action strobe
    logic strobeOff; // lower action strobe
    logic capture;   // sample sense line, return to relax
    logic busy;      // command in progress
  } seqCtl_t;

endpackage

// File: rtl/dps_control.sv
module dps_control
  import dps_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int SETUP_US   = 1,
  parameter int STROBE_US  = 2,
  parameter int HOLD_US    = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqSense,
  output seqCtl_t ctl
);

  localparam int SETUP_CYC  = SETUP_US * CYC_PER_US;
  localparam int STROBE_CYC = STROBE_US * CYC_PER_US;
  localparam int HOLD_CYC   = HOLD_US * CYC_PER_US;
  localparam int MAX_CYC    = (SETUP_CYC > STROBE_CYC) ?
                              ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                              ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX     = CNT_W'(MAX_CYC - 1);

  seqState_e        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             isSenseQ, isSenseD;

  always_comb begin
    stateD   = stateQ;
    cntD     = cntQ;
    isSenseD = isSenseQ;
    ctl      = '0;
    ctl.busy = (stateQ != ST_IDLE);
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.ldRelax = 1'b1;
          isSenseD    = reqSense;
          stateD      = ST_RELAX;
        end
      end
      ST_RELAX: begin
        ctl.ldCode = 1'b1;
        cntD       = '0;
        stateD     = ST_SETUP;
      end
      ST_SETUP: begin
        if (cntQ == SETUP_LAST) begin
          cntD = '0;
          if (isSenseQ) begin
            ctl.capture = 1'b1;
            stateD      = ST_IDLE;
          end else begin
            ctl.strobeOn = 1'b1;
            stateD       = ST_PULSE;
          end
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_PULSE: begin
        if (cntQ == STROBE_LAST) begin
          cntD          = '0;
          ctl.strobeOff = 1'b1;
          stateD        = ST_HOLD;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cntQ == HOLD_LAST) begin
          cntD   = '0;
          stateD = ST_IDLE;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      isSenseQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      cntQ     <= cntD;
      isSenseQ <= isSenseD;
    end
  end

  // R4: delay counter never runs past the longest window
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= CNT_MAX);

  // R7: command kind is frozen while a command runs
  p_kind_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ != ST_IDLE) && (stateQ != ST_RELAX) |-> $stable(isSenseQ));

  // R6: a sense command never reaches the strobe states
  p_sense_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    isSenseQ && (stateQ != ST_IDLE) |-> (stateQ != ST_PULSE) && (stateQ != ST_HOLD));

endmodule

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int          CODE_W     = 4,
  parameter logic [2:0]  RELAX_CODE = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCtl_t           ctl,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              senseIn,
  output logic [2:0]        phaseLines,
  output logic              driveSel,
  output logic              strobe,
  output logic              senseValid,
  output logic              senseBit
);

  logic [CODE_W-1:0] codeQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeQ      <= '0;
      phaseLines <= RELAX_CODE;
      driveSel   <= 1'b0;
      strobe     <= 1'b0;
      senseValid <= 1'b0;
      senseBit   <= 1'b0;
    end else begin
      senseValid <= 1'b0;
      if (ctl.ldRelax) begin
        codeQ      <= reqCode;
        phaseLines <= RELAX_CODE;
      end
      if (ctl.ldCode) begin
        phaseLines <= codeQ[2:0];
        driveSel   <= codeQ[3];
      end
      if (ctl.strobeOn)  strobe <= 1'b1;
      if (ctl.strobeOff) strobe <= 1'b0;
      if (ctl.capture) begin
        senseBit   <= ~senseIn;
        senseValid <= 1'b1;
        phaseLines <= RELAX_CODE;
      end
    end
  end

  // R2: the new code is only applied over the relax code
  p_relax_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ldCode |-> phaseLines == RELAX_CODE);

  // R4: lines hold still while the strobe is high
  p_lines_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && $past(strobe) |-> $stable(phaseLines) && $stable(driveSel));

  // R6: sense capture never coincides with the strobe, pulse is one cycle
  p_sense_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    senseValid |-> !strobe);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    senseValid |=> !senseValid);

  // R7: latched code is frozen while busy
  p_code_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.busy && $past(ctl.busy) |-> $stable(codeQ));

  // R8: sensed bit only moves on a capture
  p_bit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl.capture) |-> $stable(senseBit));

endmodule

// File: rtl/drive_phase_sequencer.sv
module drive_phase_sequencer
  import dps_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int SETUP_US   = 1,
  parameter int STROBE_US  = 2,
  parameter int HOLD_US    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [3:0] reqCode,
  input  logic       reqSense,
  output logic       busy,
  output logic [2:0] phaseLines,
  output logic       driveSel,
  output logic       strobe,
  input  logic       senseIn,
  output logic       senseValid,
  output logic       senseBit
);

  seqCtl_t ctl;

  dps_control #(
    .CYC_PER_US(CYC_PER_US),
    .SETUP_US  (SETUP_US),
    .STROBE_US (STROBE_US),
    .HOLD_US   (HOLD_US)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .reqSense(reqSense),
    .ctl     (ctl)
  );

  dps_datapath #(
    .CODE_W    (4),
    .RELAX_CODE(3'd3)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .reqCode   (reqCode),
    .senseIn   (senseIn),
    .phaseLines(phaseLines),
    .driveSel  (driveSel),
    .strobe    (strobe),
    .senseValid(senseValid),
    .senseBit  (senseBit)
  );

  assign busy = ctl.busy;

endmodule

// File: tb/tb_drive_phase_sequencer.sv
module tb_drive_phase_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int US   = 4;
  localparam int SCYC = 1 * US;
  localparam int WCYC = 2 * US;
  localparam int HCYC = 1 * US;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0;
  logic [3:0] reqCode = '0;
  logic       reqSense = 1'b0;
  logic       busy, driveSel, strobe, senseValid, senseBit, senseIn;
  logic [2:0] phaseLines;
  logic [15:0] senseTable = 16'h0;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic [2:0] curPhase = 3'd3;
  logic       curSel   = 1'b0;
  logic       lastBit  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // drive model: sense line answers for the code on the lines
  assign senseIn = senseTable[{driveSel, phaseLines}];

  drive_phase_sequencer #(.CYC_PER_US(US)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqCode(reqCode),
    .reqSense(reqSense), .busy(busy), .phaseLines(phaseLines),
    .driveSel(driveSel), .strobe(strobe), .senseIn(senseIn),
    .senseValid(senseValid), .senseBit(senseBit)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int opLen(input logic isSense);
    return isSense ? (1 + SCYC) : (1 + SCYC + WCYC + HCYC);
  endfunction

  function automatic logic expStrobe(input logic isSense, input int k);
    return !isSense && (k >= 1 + SCYC) && (k < 1 + SCYC + WCYC);
  endfunction

  // run one command; strayAt >= 0 issues an ignored request at that cycle
  task automatic runOp(input logic [3:0] code, input logic isSense, input int strayAt);
    int t;
    logic expB;
    t = opLen(isSense);
    expB = !senseTable[code];
    @(negedge clk);
    reqValid = 1'b1; reqCode = code; reqSense = isSense;
    for (int k = 0; k <= t + 1; k++) begin
      @(negedge clk);
      if (k == strayAt) begin
        reqValid = 1'b1; reqCode = ~code; reqSense = ~isSense;
      end else begin
        reqValid = 1'b0; reqCode = 4'h0; reqSense = 1'b0;
      end
      if (k == 0) begin
        check("R2", "busy", busy, 1);
        check("R2", "relax phase", phaseLines, 3);
        check("R2", "driveSel held", driveSel, curSel);
      end else if (k < t) begin
        check("R3", "phase", phaseLines, code[2:0]);
        check("R3", "driveSel", driveSel, code[3]);
        check("R7", "busy", busy, 1);
        check(isSense ? "R6" : "R4", "strobe", strobe, expStrobe(isSense, k));
        check("R6", "senseValid low", senseValid, 0);
        check("R8", "senseBit held", senseBit, lastBit);
      end else if (k == t) begin
        check(isSense ? "R6" : "R5", "busy end", busy, 0);
        check(isSense ? "R6" : "R5", "phase end", phaseLines, isSense ? 3 : code[2:0]);
        check(isSense ? "R6" : "R5", "driveSel end", driveSel, code[3]);
        check("R4", "strobe low", strobe, 0);
        check("R6", "senseValid", senseValid, isSense);
        if (isSense) begin
          check("R6", "senseBit", senseBit, expB);
          lastBit = expB;
        end else begin
          check("R8", "senseBit held", senseBit, lastBit);
        end
      end else begin
        check("R7", "stays idle", busy, 0);
        check("R6", "valid one cycle", senseValid, 0);
        check("R7", "phase idle", phaseLines, isSense ? 3 : code[2:0]);
      end
    end
    curSel = code[3];
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        nFails++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "phase", phaseLines, 3);
    check("R1", "driveSel", driveSel, 0);
    check("R1", "strobe", strobe, 0);
    check("R1", "busy", busy, 0);
    check("R1", "senseValid", senseValid, 0);

    // directed actions: step direction, motor on, eject, GCR mode
    runOp(4'd0, 1'b0, -1);
    runOp(4'd2, 1'b0, -1);
    runOp(4'd7, 1'b0, 3);            // R7 stray during setup
    runOp(4'd13, 1'b0, 2 + SCYC);    // R7 stray during strobe
    runOp(4'd9, 1'b0, opLen(1'b0) - 1); // R7 stray in last busy cycle
    // directed senses: disk in present/absent, seek complete
    senseTable = 16'h0000;
    runOp(4'd8, 1'b1, -1);           // line 0 -> bit 1
    senseTable = 16'hFFFF;
    runOp(4'd8, 1'b1, -1);           // line 1 -> bit 0
    runOp(4'd15, 1'b1, opLen(1'b1) - 1);
    senseTable = 16'h4000;
    runOp(4'd14, 1'b1, 1);
    runOp(4'd3, 1'b0, -1);           // relax code as action

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [3:0] c;
      logic s;
      int stray;
      senseTable = 16'($urandom());
      c = 4'($urandom_range(0, 15));
      s = 1'($urandom_range(0, 1));
      stray = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, opLen(s) - 1)) : -1;
      runOp(c, s, stray);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule